// File: doc/BRIEF.md
# Lane Power Sequencer

This block powers serial link lanes on or off, one at a time, when it receives a single command. The command carries a lane count (1, 2 or 4), a direction (power on or power off), a link-type select that sets the spacing between lanes, and a start strobe. The block steps through the lanes, waits for each pad to report that it has settled, and then raises a one-cycle completion pulse. After a power-on command it also drives a timed common-mode precharge pulse on the lanes that are now active.

Its timebase is a prescaler on the system clock. The prescaler produces a tick every `TICK_DIV` cycles, and `US_TICKS` ticks make one microsecond. The inter-lane spacing, the settle timeout and the precharge length are all counted in these ticks. The block keeps the result of the last command (the error flag and the encoded lane count) until it accepts the next one.

Top module: `lane_pwr_seq`

## Requirements
- R1: After reset, `lane_pd` is 4'b1111, `cal_pd` is 1, `cm_pre` is 0, `lane_code` is 2'b00, and `busy` and `err` are 0. An accepted command with count 1, 2 or 4 sets `lane_code` to 2'b01, 2'b10 or 2'b11 respectively. Its lane set is lane 0, lanes 0–1, or lanes 0–3.
- R2: A start with any other count is rejected. `err` goes to 1 and `done` pulses in the cycle after the strobe. `busy` stays 0, and `lane_pd` and `lane_code` keep their previous values.
- R3: A power-on command clears the `lane_pd` bit of each lane in its set in ascending order, starting at lane 0. It moves to the next lane only after the current lane's `pad_ready` bit reads 1. Lanes outside the set are left as they were.
- R4: A power-off command with count N sets the `lane_pd` bit of lanes 3 down to N, in descending order. Each lane waits for its `pad_ready` bit to read 0. Lanes below N stay on. A power-off command sets `cal_pd` to 1 and a power-on command clears it.
- R5: After switching each lane, the block waits `DLY_DP` ticks (1) when `lvds_sel`=0, or `DLY_LVDS` ticks (15) when `lvds_sel`=1, before it checks that lane's pad.
- R6: `busy` is high from the cycle after an accepted start until completion. `done` is a one-cycle pulse in the first cycle that `busy` is low again. `err` is cleared when a command is accepted and then holds its value.
- R7: If a lane's `pad_ready` does not reach the expected level within `TMO_TICKS` ticks, the block sets `err`, abandons the command and skips the precharge. It leaves `lane_pd` as it stands at that point.
- R8: After a successful power-on, `cm_pre` equals the mask of the command's lane set for `PRECHG_US` microseconds. All four bits then return to 0, and only after that does `done` pulse. `cm_pre` is never high on a lane that is powered down.
- R9: A start strobe that arrives while `busy` is high has no effect on the running command or on its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Command strobe, sampled when idle |
| pwr_up | input | 1 | 1 = power lanes on, 0 = power lanes off |
| lvds_sel | input | 1 | Selects the long inter-lane spacing |
| lane_req | input | 3 | Requested lane count (1, 2 or 4) |
| pad_ready | input | 4 | Per-lane pad settled indication (1 = powered) |
| lane_pd | output | 4 | Per-lane power-down, 1 = off |
| cm_pre | output | 4 | Per-lane common-mode precharge drive |
| cal_pd | output | 1 | Pad calibration power-down |
| lane_code | output | 2 | Encoded lane count of last accepted command |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last command rejected or timed out |

## Verification
The bench records the cycle at which each lane bit changes. This catches a sequencer that walks the lanes in the wrong direction, or that touches lanes outside the requested set: lane 0 would drop on a shrink, or lanes 2–3 would come up for a two-lane request. It measures the gap between lanes for both link types, so an inverted link-type select shows up as a gap roughly 15 times too short or too long. It also measures the precharge width and mask, which exposes a pulse that is cut short or one that drives idle lanes. The remaining cases are an illegal count (which must leave the lanes and the code untouched), a strobe injected while a command runs, and a pad that never settles. In that last case a broken design would hang, or would report success and run the precharge anyway.

// File: rtl/lane_pwr_seq.sv
module lane_pwr_seq #(
  parameter int TICK_DIV  = 25,
  parameter int US_TICKS  = 10,
  parameter int PRECHG_US = 100,
  parameter int DLY_DP    = 1,
  parameter int DLY_LVDS  = 15,
  parameter int TMO_TICKS = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       pwr_up,
  input  logic       lvds_sel,
  input  logic [2:0] lane_req,
  input  logic [3:0] pad_ready,
  output logic [3:0] lane_pd,
  output logic [3:0] cm_pre,
  output logic       cal_pd,
  output logic [1:0] lane_code,
  output logic       busy,
  output logic       done,
  output logic       err
);
  localparam int PRE_T = PRECHG_US * US_TICKS;
  localparam int MAX_A = (PRE_T > TMO_TICKS) ? PRE_T : TMO_TICKS;
  localparam int MAX_T = (MAX_A > DLY_LVDS) ? MAX_A : DLY_LVDS;
  localparam int TW    = $clog2(MAX_T + 1) + 1;
  localparam int PW    = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  typedef enum logic [2:0] {S_IDLE, S_STEP, S_DLY, S_RDY, S_PRE, S_FIN} st_t;
  st_t st;

  logic [PW-1:0] pcnt;
  logic [TW-1:0] timer, dly_q;
  logic [3:0]    mask_q;
  logic [1:0]    idx;
  logic          up_q;

  wire tick   = (pcnt == PW'(TICK_DIV - 1));
  wire req_ok = (lane_req == 3'd1) || (lane_req == 3'd2) || (lane_req == 3'd4);
  wire [3:0] req_mask = (lane_req == 3'd4) ? 4'hF : (lane_req == 3'd2) ? 4'h3 : 4'h1;
  wire [1:0] req_code = (lane_req == 3'd4) ? 2'd3 : (lane_req == 3'd2) ? 2'd2 : 2'd1;
  wire up_last = (idx == 2'd3) || !mask_q[idx + 2'd1];
  wire dn_last = mask_q[idx - 2'd1];
  wire accept  = start && (st == S_IDLE);
  wire [TW-1:0] timer_nx = timer + 1'b1;

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt <= '0;
    else if (accept || tick) pcnt <= '0;
    else pcnt <= pcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; lane_pd <= 4'hF; cm_pre <= 4'h0; cal_pd <= 1'b1;
      lane_code <= 2'd0; done <= 1'b0; err <= 1'b0;
      timer <= '0; dly_q <= '0; mask_q <= 4'h1; idx <= 2'd0; up_q <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (!req_ok) begin
            err <= 1'b1; done <= 1'b1;
          end else begin
            err <= 1'b0; lane_code <= req_code; mask_q <= req_mask; up_q <= pwr_up;
            dly_q <= lvds_sel ? TW'(DLY_LVDS) : TW'(DLY_DP);
            cal_pd <= !pwr_up; timer <= '0;
            if (pwr_up) begin idx <= 2'd0; st <= S_STEP; end
            else if (req_mask[3]) st <= S_FIN;
            else begin idx <= 2'd3; st <= S_STEP; end
          end
        end
        S_STEP: begin
          lane_pd[idx] <= !up_q; timer <= '0; st <= S_DLY;
        end
        S_DLY: if (tick) begin
          if (timer_nx >= dly_q) begin timer <= '0; st <= S_RDY; end
          else timer <= timer_nx;
        end
        S_RDY: begin
          if (pad_ready[idx] == up_q) begin
            timer <= '0;
            if (up_q) begin
              if (up_last) begin cm_pre <= mask_q; st <= S_PRE; end
              else begin idx <= idx + 2'd1; st <= S_STEP; end
            end else begin
              if (dn_last) st <= S_FIN;
              else begin idx <= idx - 2'd1; st <= S_STEP; end
            end
          end else if (tick) begin
            if (timer_nx >= TW'(TMO_TICKS)) begin err <= 1'b1; st <= S_FIN; end
            else timer <= timer_nx;
          end
        end
        S_PRE: if (tick) begin
          if (timer_nx >= TW'(PRE_T)) begin cm_pre <= 4'h0; st <= S_FIN; end
          else timer <= timer_nx;
        end
        S_FIN: begin done <= 1'b1; st <= S_IDLE; end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r8_pre_on_live_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_pre & lane_pd) == 4'h0);
  a_r3_up_never_disables: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && up_q && $past(busy)) |-> ((lane_pd & ~$past(lane_pd)) == 4'h0));
  a_r4_down_never_enables: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !up_q && $past(busy)) |-> ((~lane_pd & $past(lane_pd)) == 4'h0));
  a_r2_reject_bad_count: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !req_ok) |=> (err && done && !busy && $stable(lane_pd) && $stable(lane_code)));
  a_r9_code_only_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lane_code) |-> $past(start && !busy));
endmodule

// File: tb/tb_lane_pwr_seq.sv
module tb_lane_pwr_seq;
  localparam int DIV = 25, UST = 10, PUS = 100, DDP = 1, DLV = 15, TMO = 200;
  localparam int PRE_CYC = PUS * UST * DIV;

  logic clk = 0, rst_n = 0, start = 0, pwr_up = 0, lvds_sel = 0;
  logic [2:0] lane_req = 0;
  logic [3:0] stuck_lo = 0, stuck_hi = 0;
  logic [3:0] pad_ready, lane_pd, cm_pre;
  logic cal_pd, busy, done, err;
  logic [1:0] lane_code;

  always #2 clk = ~clk;
  assign pad_ready = (~lane_pd & ~stuck_lo) | stuck_hi;

  lane_pwr_seq #(.TICK_DIV(DIV), .US_TICKS(UST), .PRECHG_US(PUS), .DLY_DP(DDP),
    .DLY_LVDS(DLV), .TMO_TICKS(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pwr_up(pwr_up), .lvds_sel(lvds_sel),
    .lane_req(lane_req), .pad_ready(pad_ready), .lane_pd(lane_pd), .cm_pre(cm_pre),
    .cal_pd(cal_pd), .lane_code(lane_code), .busy(busy), .done(done), .err(err));

  int n_chk = 0, n_fail = 0;
  int chg[4];
  int cm_cnt, done_cnt;
  logic [3:0] cm_or;
  logic saw_busy;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_cmd(input bit up, input bit lv, input int cnt, input bit inject);
    logic [3:0] prev;
    bit fin;
    fin = 0; cm_cnt = 0; done_cnt = 0; cm_or = 0; saw_busy = 0;
    for (int i = 0; i < 4; i++) chg[i] = -1;
    @(negedge clk);
    prev = lane_pd;
    start = 1; pwr_up = up; lvds_sel = lv; lane_req = 3'(cnt);
    @(negedge clk);
    start = 0;
    for (int k = 0; k < 120000 && !fin; k++) begin
      for (int i = 0; i < 4; i++)
        if (lane_pd[i] != prev[i] && chg[i] < 0) chg[i] = k;
      prev = lane_pd;
      if (cm_pre != 0) cm_cnt++;
      cm_or |= cm_pre;
      if (busy) saw_busy = 1;
      if (done) begin done_cnt++; fin = 1; end
      if (inject && k == 100) begin start = 1; pwr_up = 0; lane_req = 3'd1; end
      else start = 0;
      @(negedge clk);
    end
    start = 0;
    repeat (3) begin @(negedge clk); if (done) done_cnt++; end
    if (!fin) chk(0, "R6", "watchdog: done never seen", 0, 1);
  endtask

  task automatic t_reset;
    chk(lane_pd == 4'hF, "R1", "reset lane_pd", lane_pd, 15);
    chk(cal_pd == 1, "R1", "reset cal_pd", cal_pd, 1);
    chk(cm_pre == 0, "R1", "reset cm_pre", cm_pre, 0);
    chk(lane_code == 0, "R1", "reset lane_code", lane_code, 0);
    chk(busy == 0 && err == 0, "R1", "reset busy/err", {busy, err}, 0);
  endtask

  task automatic t_up2_dp;
    do_cmd(1, 0, 2, 0);
    chk(lane_pd == 4'b1100, "R1", "two-lane set", lane_pd, 12);
    chk(lane_code == 2'b10, "R1", "code for 2", lane_code, 2);
    chk(err == 0 && saw_busy, "R6", "success err/busy", err, 0);
    chk(done_cnt == 1, "R6", "single done pulse", done_cnt, 1);
    chk(chg[0] >= 0 && chg[1] > chg[0], "R3", "lane0 before lane1", chg[1], chg[0] + 1);
    chk(chg[2] < 0 && chg[3] < 0, "R3", "lanes 2-3 untouched", chg[2], -1);
    chk(chg[1] - chg[0] <= DDP * DIV + 4, "R5", "DP spacing", chg[1] - chg[0], DDP * DIV);
    chk(cm_or == 4'b0011, "R8", "precharge mask", cm_or, 3);
    chk(cm_cnt >= PRE_CYC - DIV && cm_cnt <= PRE_CYC + DIV, "R8", "precharge width", cm_cnt, PRE_CYC);
    chk(cm_pre == 0, "R8", "precharge released", cm_pre, 0);
    chk(cal_pd == 0, "R4", "cal_pd cleared on power-on", cal_pd, 0);
  endtask

  task automatic t_bad_count;
    do_cmd(1, 0, 3, 0);
    chk(err == 1, "R2", "count 3 rejected", err, 1);
    chk(lane_pd == 4'b1100, "R2", "lanes unchanged", lane_pd, 12);
    chk(lane_code == 2'b10, "R2", "code unchanged", lane_code, 2);
    chk(!saw_busy && done_cnt == 1, "R2", "no busy, one done", saw_busy, 0);
  endtask

  task automatic t_up4_lvds;
    do_cmd(1, 1, 4, 0);
    chk(err == 0, "R6", "err cleared by accepted command", err, 0);
    chk(lane_pd == 4'b0000, "R1", "four-lane set", lane_pd, 0);
    chk(lane_code == 2'b11, "R1", "code for 4", lane_code, 3);
    chk(chg[3] > chg[2] && chg[2] >= 0, "R3", "lane2 before lane3", chg[3], chg[2] + 1);
    chk(chg[3] - chg[2] >= (DLV - 1) * DIV && chg[3] - chg[2] <= DLV * DIV + 4,
        "R5", "LVDS spacing", chg[3] - chg[2], DLV * DIV);
    chk(cm_or == 4'hF, "R8", "precharge all lanes", cm_or, 15);
  endtask

  task automatic t_down1;
    do_cmd(0, 0, 1, 0);
    chk(lane_pd == 4'b1110, "R4", "lane0 kept, rest off", lane_pd, 14);
    chk(chg[3] >= 0 && chg[2] > chg[3] && chg[1] > chg[2], "R4", "descending order", chg[1], chg[2] + 1);
    chk(chg[0] < 0, "R4", "lane0 untouched", chg[0], -1);
    chk(cal_pd == 1, "R4", "cal_pd set on power-off", cal_pd, 1);
    chk(cm_cnt == 0, "R8", "no precharge on power-off", cm_cnt, 0);
    chk(lane_code == 2'b01, "R1", "code for 1", lane_code, 1);
  endtask

  task automatic t_busy_ignore;
    do_cmd(1, 0, 4, 1);
    chk(lane_pd == 4'b0000, "R9", "strobe while busy ignored", lane_pd, 0);
    chk(lane_code == 2'b11, "R9", "code kept", lane_code, 3);
    chk(done_cnt == 1, "R9", "only one completion", done_cnt, 1);
    chk(cal_pd == 0, "R9", "cal_pd kept", cal_pd, 0);
  endtask

  task automatic t_timeout;
    stuck_hi = 4'b1000;
    do_cmd(0, 0, 2, 0);
    chk(err == 1, "R7", "timeout flagged", err, 1);
    chk(lane_pd == 4'b1000, "R7", "abandoned after lane3", lane_pd, 8);
    chk(done_cnt == 1, "R7", "done after timeout", done_cnt, 1);
    chk(err == 1, "R6", "err held while idle", err, 1);
    stuck_hi = 0;
    do_cmd(1, 0, 1, 0);
    chk(err == 0, "R6", "err cleared by next command", err, 0);
    stuck_lo = 4'b0001;
    do_cmd(0, 0, 2, 0);
    do_cmd(1, 0, 4, 0);
    chk(err == 1 && cm_cnt == 0, "R7", "power-on timeout skips precharge", cm_cnt, 0);
    stuck_lo = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_up2_dp();
    t_bad_count();
    t_up4_lvds();
    t_down1();
    t_busy_ignore();
    t_timeout();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #3000000;
    n_chk++; n_fail++;
    $display("FAIL R6 watchdog expired: actual 0 expected 1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule